// File: doc/BRIEF.md
# Two-Wire Bus Slave with Target Routing

This block is a slave on a two-wire serial bus. It watches an oversampled clock line and data line, finds START and STOP, and shifts in an address byte. The upper four bits of that byte are a fixed device type. The next three bits choose one of two internal register spaces: a bank of potentiometer wiper settings, or a control/status register. Codes that match neither space are refused.

After a write address the block acknowledges every data byte. It hands each complete byte to an internal register port as one strobe, tagged with the chosen target. After a read address it fetches a byte from the same port and shifts it out MSB first. It keeps fetching and sending while the master acknowledges. When the master does not acknowledge, it stops and stays off the line.

The data line is open-drain. The block only ever requests a low level through `sda_oe`, and the pad and pull-up are outside it.

Top module: `tws_target_slave`

## Requirements
- R1: A START (data line falling while the clock line is high) begins a new address phase from any state, including the middle of a byte. Bus traffic before the first START gets no ACK and no drive.
- R2: Address bits 7 to 4 must equal 1010. Any other value gets a NACK and causes no register strobe.
- R3: Address bits 3 to 1 equal to 111 select the wiper bank (`reg_tgt` = 0). Bits 3 to 1 equal to 010 select the control/status register (`reg_tgt` = 1). Both get an ACK on the ninth clock.
- R4: Every other value of address bits 3 to 1 is reserved and gets a NACK. `reg_wr` and `reg_rd` never pulse in the same cycle.
- R5: With address bit 0 = 0 (write), each data byte received MSB first is acknowledged on the ninth clock. It is committed as a single-cycle `reg_wr` pulse carrying the byte on `reg_wdata` and the target on `reg_tgt`.
- R6: With address bit 0 = 1 (read), after the address ACK the block pulses `reg_rd` for one cycle and captures `reg_rdata` in that cycle. It shifts the byte out MSB first, pulling the line low only for 0 bits, and does another fetch after each master ACK.
- R7: After a master NACK the block releases the data line and drives nothing until the next START.
- R8: During and right after reset, `sda_oe`, `reg_wr` and `reg_rd` are low.
- R9: A STOP (data line rising while the clock line is high) returns the block to idle from any state. A byte that is cut short is never committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired level) |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| reg_wr | output | 1 | One-cycle commit strobe for a received byte |
| reg_rd | output | 1 | One-cycle fetch strobe; `reg_rdata` is captured in this cycle |
| reg_tgt | output | 1 | Selected space: 0 wiper bank, 1 control/status |
| reg_wdata | output | 8 | Byte being committed |
| reg_rdata | input | 8 | Byte returned by the selected space |

## Verification
A wrong state register shows up on the data line within one bus bit. It appears as an ACK where a NACK was due, as a low pulled outside an acknowledge or read slot, or as a read bit that differs from the fetched byte. A broken bit counter or shift path moves or corrupts the byte on `reg_wdata`, or the strobe lands a clock late. This is seen when the byte completes. A lost START or STOP leaves the next transaction without an ACK. The bench checks line ownership on every system clock, so a stray drive is reported within one cycle.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam logic [2:0] SEL_WIPER = 3'b111;
    localparam logic [2:0] SEL_CTRL  = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } state_e;

    typedef enum logic {
        TGT_WIPER = 1'b0,
        TGT_CTRL  = 1'b1
    } target_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic    hit;
        target_e tgt;
        logic    rd;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [BYTE_W-1:0] b);
        addr_dec_t d;
        d.rd  = b[0];
        d.tgt = (b[3:1] == SEL_CTRL) ? TGT_CTRL : TGT_WIPER;
        d.hit = (b[7:4] == DEV_TYPE) &&
                ((b[3:1] == SEL_WIPER) || (b[3:1] == SEL_CTRL));
        return d;
    endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    // Idle bus is high on both lines, so reset to ones to avoid false edges.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.start    = scl_s && scl_d && sda_d && !sda_s;
        evt.stop     = scl_s && scl_d && !sda_d && sda_s;
        evt.scl_rise = scl_s && !scl_d;
        evt.scl_fall = !scl_s && scl_d;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/tws_addr_decode.sv
module tws_addr_decode
    import tws_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    output addr_dec_t         dec
);

    always_comb dec = decode_addr(addr_byte);

endmodule

// File: rtl/tws_proto_fsm.sv
module tws_proto_fsm
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  addr_dec_t         dec,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] shift_o,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output target_e           tgt,
    output logic [BYTE_W-1:0] wdata
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    state_e            state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw_rd;
    logic              m_ack;

    assign shift_o = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rw_rd  <= 1'b0;
            m_ack  <= 1'b0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            tgt    <= TGT_WIPER;
            wdata  <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (evt.stop) begin
                state <= ST_IDLE;
            end else if (evt.start) begin
                state <= ST_ADDR;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == FULL) begin
                            if (state == ST_WR_BYTE) begin
                                wr_stb <= 1'b1;
                                wdata  <= sh;
                                state  <= ST_WR_ACK;
                            end else if (dec.hit) begin
                                tgt   <= dec.tgt;
                                rw_rd <= dec.rd;
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (state == ST_ADDR_ACK && rw_rd) begin
                                sh     <= rdata;
                                rd_stb <= 1'b1;
                                state  <= ST_RD_BYTE;
                            end else begin
                                state <= ST_WR_BYTE;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_fall) begin
                            if (cnt == LAST) begin
                                cnt   <= '0;
                                state <= ST_RD_ACK;
                            end else begin
                                sh  <= {sh[BYTE_W-2:0], 1'b0};
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            m_ack <= !evt.sda;
                        end else if (evt.scl_fall) begin
                            if (m_ack) begin
                                sh     <= rdata;
                                rd_stb <= 1'b1;
                                state  <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = (state == ST_ADDR_ACK) || (state == ST_WR_ACK) ||
                 ((state == ST_RD_BYTE) && !sh[BYTE_W-1]);
    end

endmodule

// File: rtl/tws_target_slave.sv
module tws_target_slave
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic              reg_tgt,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);

    bus_evt_t          bus_evt;
    addr_dec_t         addr_dec;
    logic [BYTE_W-1:0] shift_byte;
    target_e           tgt_sel;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (bus_evt)
    );

    tws_addr_decode u_dec (
        .addr_byte (shift_byte),
        .dec       (addr_dec)
    );

    tws_proto_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (bus_evt),
        .dec     (addr_dec),
        .rdata   (reg_rdata),
        .shift_o (shift_byte),
        .sda_oe  (sda_oe),
        .wr_stb  (reg_wr),
        .rd_stb  (reg_rd),
        .tgt     (tgt_sel),
        .wdata   (reg_wdata)
    );

    assign reg_tgt = tgt_sel;

endmodule

// File: rtl/tws_target_slave_chk.sv
module tws_target_slave_chk (
    input logic clk,
    input logic rst,
    input logic start_evt,
    input logic stop_evt,
    input logic sda_oe,
    input logic reg_wr,
    input logic reg_rd
);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !sda_oe);

    // R1
    start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (!sda_oe && !reg_wr && !reg_rd));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !reg_wr && !reg_rd));

endmodule

bind tws_target_slave tws_target_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_evt (bus_evt.start),
    .stop_evt  (bus_evt.stop),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd)
);

// File: tb/tws_target_slave_test.sv
module tws_target_slave_test;

    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, reg_wr, reg_rd, reg_tgt;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;

    int   checks = 0;
    int   fails  = 0;
    bit   allow_drive = 1'b0;
    int   rd_idx = 0;
    int   exp_idx = 0;
    int   rd_pulses = 0;
    logic [8:0] exp_wr_q[$];

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = (reg_tgt ? 8'hC5 : 8'h3A) + 8'(rd_idx * 7);

    tws_target_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_tgt   (reg_tgt),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Per-clock model comparison: line ownership and register-port strobes.
    always @(posedge clk) if (reg_rd) rd_idx <= rd_idx + 1;

    always @(negedge clk) begin
        if (!rst) begin
            check(!(sda_oe && !allow_drive), "R7", "drive outside slave slot",
                  int'(sda_oe), 0);
            if (reg_rd) rd_pulses++;
            if (reg_wr) begin
                if (exp_wr_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected write", int'({reg_tgt, reg_wdata}), 0);
                end else begin
                    logic [8:0] e;
                    e = exp_wr_q.pop_front();
                    check({reg_tgt, reg_wdata} == e, "R5", "write tgt/data",
                          int'({reg_tgt, reg_wdata}), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(2 * H);
    endtask

    task automatic send_bit(input bit b);
        m_sda = b;
        tick(4);
        allow_drive = 1'b0;
        tick(H - 4);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output bit b);
        allow_drive = 1'b1;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        b = sda_line;
        tick(H / 2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] d, output bit acked);
        bit x;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(x);
        acked = !x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit give_ack);
        bit x;
        for (int i = 0; i < 8; i++) begin
            recv_bit(x);
            d = {d[6:0], x};
        end
        send_bit(!give_ack);
    endtask

    task automatic read_expect(input bit ctrl, input bit give_ack, input string req);
        logic [7:0] d;
        logic [7:0] e;
        e = (ctrl ? 8'hC5 : 8'h3A) + 8'(exp_idx * 7);
        recv_byte(d, give_ack);
        exp_idx++;
        check(d == e, req, "read byte", int'(d), int'(e));
    endtask

    initial begin
        bit ack;
        bit b;

        // R8: reset state
        tick(5);
        check(!sda_oe && !reg_wr && !reg_rd, "R8", "outputs in reset",
              int'({sda_oe, reg_wr, reg_rd}), 0);
        rst = 1'b0;
        tick(3);
        check(!sda_oe && !reg_wr && !reg_rd, "R8", "outputs after reset",
              int'({sda_oe, reg_wr, reg_rd}), 0);

        // R1: valid address without a START is ignored
        send_byte(8'hAE, ack);
        check(!ack, "R1", "ack without START", int'(ack), 0);
        bus_stop();

        // R3 and R5: write two bytes to the wiper bank
        bus_start();
        send_byte(8'hAE, ack);
        check(ack, "R3", "wiper address ack", int'(ack), 1);
        exp_wr_q.push_back({1'b0, 8'h5A});
        send_byte(8'h5A, ack);
        check(ack, "R5", "data ack 1", int'(ack), 1);
        exp_wr_q.push_back({1'b0, 8'h81});
        send_byte(8'h81, ack);
        check(ack, "R5", "data ack 2", int'(ack), 1);
        bus_stop();
        check(exp_wr_q.size() == 0, "R5", "wiper writes committed", exp_wr_q.size(), 0);

        // R3: write to control/status
        bus_start();
        send_byte(8'hA4, ack);
        check(ack, "R3", "control address ack", int'(ack), 1);
        exp_wr_q.push_back({1'b1, 8'h3C});
        send_byte(8'h3C, ack);
        check(ack, "R5", "control data ack", int'(ack), 1);
        bus_stop();
        check(exp_wr_q.size() == 0, "R3", "control write committed", exp_wr_q.size(), 0);

        // R2: wrong type field
        bus_start();
        send_byte(8'hBE, ack);
        check(!ack, "R2", "bad type nack", int'(ack), 0);
        send_byte(8'h11, ack);
        check(!ack, "R2", "data after bad type", int'(ack), 0);
        bus_stop();

        // R4: reserved selector codes
        bus_start();
        send_byte(8'hA2, ack);
        check(!ack, "R4", "selector 001 nack", int'(ack), 0);
        bus_stop();
        bus_start();
        send_byte(8'hAC, ack);
        check(!ack, "R4", "selector 110 nack", int'(ack), 0);
        bus_stop();

        // R6 and R7: three-byte read from the wiper bank
        rd_pulses = 0;
        bus_start();
        send_byte(8'hAF, ack);
        check(ack, "R6", "read address ack", int'(ack), 1);
        read_expect(1'b0, 1'b1, "R6");
        read_expect(1'b0, 1'b1, "R6");
        read_expect(1'b0, 1'b0, "R7");
        for (int i = 0; i < 4; i++) begin
            recv_bit(b);
            allow_drive = 1'b0;
            check(b == 1'b1, "R7", "line released after nack", int'(b), 1);
        end
        bus_stop();
        check(rd_pulses == 3, "R6", "fetch count", rd_pulses, 3);

        // R6: single-byte read from control/status
        bus_start();
        send_byte(8'hA5, ack);
        check(ack, "R6", "control read ack", int'(ack), 1);
        read_expect(1'b1, 1'b0, "R6");
        bus_stop();

        // R1: repeated START mid-byte restarts address phase
        bus_start();
        send_byte(8'hA4, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'hA4, ack);
        check(ack, "R1", "ack after repeated START", int'(ack), 1);
        exp_wr_q.push_back({1'b1, 8'h99});
        send_byte(8'h99, ack);
        bus_stop();
        check(exp_wr_q.size() == 0, "R1", "only full byte committed", exp_wr_q.size(), 0);

        // R9: STOP cuts a byte short, nothing committed, next access works
        bus_start();
        send_byte(8'hAE, ack);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        bus_stop();
        tick(4 * H);
        check(exp_wr_q.size() == 0, "R9", "no partial commit", exp_wr_q.size(), 0);
        bus_start();
        send_byte(8'hAE, ack);
        check(ack, "R9", "ack after early STOP", int'(ack), 1);
        exp_wr_q.push_back({1'b0, 8'h07});
        send_byte(8'h07, ack);
        bus_stop();
        check(exp_wr_q.size() == 0, "R9", "write after recovery", exp_wr_q.size(), 0);

        tick(10);
        finish_run();
    end

endmodule